// File: doc/BRIEF.md
# Cyclic Reorder Buffer

This block keeps one record for every instruction that has been issued but not yet retired, in a ring of power-of-two depth. Execution can finish out of program order, but the architectural register file still receives results in program order. At issue, the entry at the allocation pointer takes the destination register number and enters the issued state. A dispatch notice moves an entry into execution. A completion notice, addressed by entry index, stores the result and marks the entry finished.

Each cycle the entry at the retire pointer is checked. If it is finished, its destination and result go out on a single register write port and the entry is freed. Younger finished entries wait behind it. A flush input names the oldest entry to discard after a mispredicted branch. That entry and everything younger are freed, and the allocation pointer moves back to it. Full and empty are derived from a pair of pointers, each one bit wider than the index.

Top module: `reorder_buf`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, `full` is 0, `iss_ready` is 1, `ret_we` is 0 and `iss_tag` is 0.
- R2: An issue is accepted when `iss_valid` is high, the buffer is not full and no flush is requested. `iss_tag` always shows the index the next accepted issue takes. Successive accepted issues take successive indices modulo the depth.
- R3: With DEPTH entries occupied, `full` is 1 and `iss_ready` is 0. An issue request in that state is ignored: no entry is allocated and `iss_tag` does not move.
- R4: `ret_we` is high only when the oldest occupied entry is finished. It then presents that entry's destination on `ret_dest` and its stored result on `ret_data`. A finished younger entry never retires ahead of an unfinished older one.
- R5: A dispatch notice on an issued entry moves it to the in-execution state. That entry does not become eligible to retire.
- R6: A completion notice on an issued or in-execution entry stores `cmpl_data` and marks the entry finished. A completion notice that names a free entry is ignored and does not retire anything.
- R7: At most one entry retires per cycle. A retired entry is freed. `empty` returns to 1 when the last occupied entry retires.
- R8: A flush discards the entry at `flush_tag` and every younger entry, and the next accepted issue takes index `flush_tag`. In the flush cycle no issue is accepted and nothing retires. A completion for an entry that survives the flush still takes effect in that cycle.
- R9: `full` and `empty` are never both 1. When `empty` is 1, the entry at the retire pointer is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Issue request for a new instruction |
| iss_dest | input | REG_W | Destination register number of the issuing instruction |
| iss_ready | output | 1 | Buffer can accept an issue (not full) |
| iss_tag | output | IDX_W | Index that the next accepted issue takes |
| disp_valid | input | 1 | Dispatch notice |
| disp_tag | input | IDX_W | Entry index of the dispatched instruction |
| cmpl_valid | input | 1 | Completion notice from an execution unit |
| cmpl_tag | input | IDX_W | Entry index of the completed instruction |
| cmpl_data | input | DATA_W | Result value of the completed instruction |
| flush_valid | input | 1 | Discard the named entry and all younger entries |
| flush_tag | input | IDX_W | Oldest entry to discard |
| ret_we | output | 1 | Register file write strobe for the retiring entry |
| ret_dest | output | REG_W | Destination register of the retiring entry |
| ret_data | output | DATA_W | Result of the retiring entry |
| full | output | 1 | All DEPTH entries occupied |
| empty | output | 1 | No entry occupied |

## Verification
The assertions rely on the execution side sending consistent notices. A dispatch names an entry that is issued. A completion names an issued or in-execution entry at most once. A flush names an entry that is occupied. The stimulus table meets these conditions by construction, with one exception. It sends a completion to a free entry on purpose, because the block must ignore that input. The bench then watches `ret_we` and `empty` to confirm that no state was touched.

// File: rtl/rob_pkg.sv
// Package: shared types of the reorder buffer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rob_pkg;

    // Life cycle of one buffer entry.
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_ISSUED = 2'd1,
        ST_EXEC   = 2'd2,
        ST_DONE   = 2'd3
    } rob_state_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
// Module: allocation and retire pointers of the ring, with full/empty
// detection and the per-entry flush mask.
// Assumes DEPTH is a power of two and flush_tag names an occupied entry.
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_req,
    input  logic             head_done,
    input  logic             flush_req,
    input  logic [IDX_W-1:0] flush_tag,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [IDX_W-1:0] ret_idx,
    output logic             full,
    output logic             empty,
    output logic             iss_fire,
    output logic             ret_fire,
    output logic [DEPTH-1:0] flush_mask
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] alloc_ptr;
    logic [PTR_W-1:0] ret_ptr;
    logic [PTR_W-1:0] used;
    logic [IDX_W-1:0] keep;

    // Occupancy and derived status.
    always_comb begin
        used      = alloc_ptr - ret_ptr;
        full      = (used == PTR_W'(DEPTH));
        empty     = (used == '0);
        alloc_idx = alloc_ptr[IDX_W-1:0];
        ret_idx   = ret_ptr[IDX_W-1:0];
        keep      = flush_tag - ret_idx;
        iss_fire  = iss_req && !full && !flush_req;
        ret_fire  = head_done && !empty && !flush_req;
    end

    // Pointer update: a flush rewinds allocation, otherwise advance on fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_ptr <= '0;
            ret_ptr   <= '0;
        end else if (flush_req) begin
            alloc_ptr <= ret_ptr + {1'b0, keep};
        end else begin
            if (iss_fire) alloc_ptr <= alloc_ptr + PTR_W'(1);
            if (ret_fire) ret_ptr   <= ret_ptr + PTR_W'(1);
        end
    end

    // Per-entry flush decision: occupied and at or beyond the flush point.
    for (genvar i = 0; i < DEPTH; i++) begin : g_mask
        logic [IDX_W-1:0] offs;
        always_comb begin
            offs          = IDX_W'(i) - ret_idx;
            flush_mask[i] = flush_req && ({1'b0, offs} < used) && (offs >= keep);
        end
    end

    p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |=> alloc_ptr == $past(alloc_ptr) + PTR_W'(1));

    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush_req) |=> alloc_ptr == $past(alloc_ptr));

    p_retire_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> ret_ptr == $past(ret_ptr) + PTR_W'(1));

    p_flush_no_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> $stable(ret_ptr));

endmodule

// File: rtl/rob_entry_state.sv
// Module: state register of every entry (free, issued, in execution,
// finished) and the head and completion qualifiers built from it.
// Assumes dispatch and completion tags name live entries; others are ignored.
module rob_entry_state
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_we,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             disp_valid,
    input  logic [IDX_W-1:0] disp_tag,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_tag,
    input  logic [DEPTH-1:0] flush_mask,
    input  logic             ret_fire,
    input  logic [IDX_W-1:0] ret_idx,
    output rob_state_e       head_state,
    output logic             head_done,
    output logic             cmpl_ok
);
    rob_state_e st [DEPTH];

    // Per-entry state machine; flush and retire free, then allocate/complete/dispatch.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [IDX_W-1:0] ME = IDX_W'(i);
        logic hit_cmpl;
        logic hit_disp;

        always_comb begin
            hit_cmpl = cmpl_valid && (cmpl_tag == ME);
            hit_disp = disp_valid && (disp_tag == ME);
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                st[i] <= ST_FREE;
            else if (flush_mask[i])
                st[i] <= ST_FREE;
            else if (ret_fire && ret_idx == ME)
                st[i] <= ST_FREE;
            else if (alloc_we && alloc_idx == ME)
                st[i] <= ST_ISSUED;
            else if (hit_cmpl && (st[i] == ST_ISSUED || st[i] == ST_EXEC))
                st[i] <= ST_DONE;
            else if (hit_disp && st[i] == ST_ISSUED)
                st[i] <= ST_EXEC;
        end

        p_dispatch_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_disp && !hit_cmpl && st[i] == ST_ISSUED && !flush_mask[i])
            |=> st[i] == ST_EXEC);

        p_flush_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
            flush_mask[i] |=> st[i] == ST_FREE);

        p_done_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == ST_DONE && !flush_mask[i] && !(ret_fire && ret_idx == ME))
            |=> st[i] == ST_DONE);
    end

    // Head view and completion acceptance for the payload store.
    always_comb begin
        head_state = st[ret_idx];
        head_done  = (head_state == ST_DONE);
        cmpl_ok    = cmpl_valid && !flush_mask[cmpl_tag] &&
                     (st[cmpl_tag] == ST_ISSUED || st[cmpl_tag] == ST_EXEC);
    end

endmodule

// File: rtl/rob_payload.sv
// Module: destination and result storage of each entry, read at the head.
// Assumes write enables are already qualified by the state logic.
module rob_payload #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dest_we,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic [REG_W-1:0]  dest_in,
    input  logic              data_we,
    input  logic [IDX_W-1:0]  data_idx,
    input  logic [DATA_W-1:0] data_in,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [REG_W-1:0]  rd_dest,
    output logic [DATA_W-1:0] rd_data
);
    logic [REG_W-1:0]  dest_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];

    // Entry-wise storage: destination at issue, result at completion.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dest_mem[i] <= '0;
                data_mem[i] <= '0;
            end else begin
                if (dest_we && dest_idx == IDX_W'(i)) dest_mem[i] <= dest_in;
                if (data_we && data_idx == IDX_W'(i)) data_mem[i] <= data_in;
            end
        end
    end

    // Head read for the register write port.
    always_comb begin
        rd_dest = dest_mem[rd_idx];
        rd_data = data_mem[rd_idx];
    end

endmodule

// File: rtl/reorder_buf.sv
// Module: top of the cyclic reorder buffer; issue, dispatch, completion,
// flush and in-order retirement through one register write port.
// Assumes execution-side notices respect entry states (see brief).
module reorder_buf
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [REG_W-1:0]  iss_dest,
    output logic              iss_ready,
    output logic [IDX_W-1:0]  iss_tag,
    input  logic              disp_valid,
    input  logic [IDX_W-1:0]  disp_tag,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_tag,
    input  logic [DATA_W-1:0] cmpl_data,
    input  logic              flush_valid,
    input  logic [IDX_W-1:0]  flush_tag,
    output logic              ret_we,
    output logic [REG_W-1:0]  ret_dest,
    output logic [DATA_W-1:0] ret_data,
    output logic              full,
    output logic              empty
);
    logic [IDX_W-1:0] alloc_idx;
    logic [IDX_W-1:0] ret_idx;
    logic             iss_fire;
    logic             ret_fire;
    logic             head_done;
    logic             cmpl_ok;
    logic [DEPTH-1:0] flush_mask;
    rob_state_e       head_state;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_req    (iss_valid),
        .head_done  (head_done),
        .flush_req  (flush_valid),
        .flush_tag  (flush_tag),
        .alloc_idx  (alloc_idx),
        .ret_idx    (ret_idx),
        .full       (full),
        .empty      (empty),
        .iss_fire   (iss_fire),
        .ret_fire   (ret_fire),
        .flush_mask (flush_mask)
    );

    rob_entry_state #(.DEPTH(DEPTH)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_we   (iss_fire),
        .alloc_idx  (alloc_idx),
        .disp_valid (disp_valid),
        .disp_tag   (disp_tag),
        .cmpl_valid (cmpl_valid),
        .cmpl_tag   (cmpl_tag),
        .flush_mask (flush_mask),
        .ret_fire   (ret_fire),
        .ret_idx    (ret_idx),
        .head_state (head_state),
        .head_done  (head_done),
        .cmpl_ok    (cmpl_ok)
    );

    rob_payload #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_pay (
        .clk      (clk),
        .rst_n    (rst_n),
        .dest_we  (iss_fire),
        .dest_idx (alloc_idx),
        .dest_in  (iss_dest),
        .data_we  (cmpl_ok),
        .data_idx (cmpl_tag),
        .data_in  (cmpl_data),
        .rd_idx   (ret_idx),
        .rd_dest  (ret_dest),
        .rd_data  (ret_data)
    );

    // Port-level view of pointers and the write strobe.
    always_comb begin
        iss_ready = !full;
        iss_tag   = alloc_idx;
        ret_we    = ret_fire;
    end

    p_empty_head_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> head_state == ST_FREE);

    p_full_not_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> head_state != ST_FREE);

endmodule

// File: tb/reorder_buf_bench.sv
// Bench: walks a table of per-cycle stimulus and expectations, then runs
// directed reset checks. Depth 4 keeps wrap and full cases short.
module reorder_buf_bench;
    localparam int DEPTH  = 4;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int NVEC   = 26;

    typedef struct packed {
        logic              iv;
        logic [REG_W-1:0]  idst;
        logic              dv;
        logic [IDX_W-1:0]  dt;
        logic              cv;
        logic [IDX_W-1:0]  ct;
        logic [DATA_W-1:0] cd;
        logic              fv;
        logic [IDX_W-1:0]  ft;
        logic              ewe;
        logic [REG_W-1:0]  edst;
        logic [DATA_W-1:0] edat;
        logic              emp;
        logic              ful;
        logic [IDX_W-1:0]  etag;
        logic [3:0]        req;
    } vec_t;

    // iv idst dv dt cv ct cd fv ft | ewe edst edat emp ful etag req
    localparam vec_t VEC [NVEC] = '{
        '{1'b1,5'd3, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b1,1'b0,2'd0, 4'd2},
        '{1'b1,5'd5, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd1, 4'd2},
        '{1'b1,5'd7, 1'b1,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd2, 4'd5},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b1,2'd1,16'h0011, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd3, 4'd4},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd3, 4'd5},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b1,2'd0,16'h0022, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd3, 4'd6},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b1,5'd3, 16'h0022, 1'b0,1'b0,2'd3, 4'd7},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b1,5'd5, 16'h0011, 1'b0,1'b0,2'd3, 4'd7},
        '{1'b1,5'd9, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd3, 4'd2},
        '{1'b1,5'd10,1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd0, 4'd2},
        '{1'b1,5'd11,1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd1, 4'd2},
        '{1'b1,5'd12,1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b1,2'd2, 4'd3},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b1,2'd2,16'h0033, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b1,2'd2, 4'd3},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b1,5'd7, 16'h0033, 1'b0,1'b1,2'd2, 4'd4},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b1,2'd0,16'h0044, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd2, 4'd6},
        '{1'b1,5'd13,1'b0,2'd0, 1'b1,2'd3,16'h0055, 1'b1,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd2, 4'd8},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b1,5'd9, 16'h0055, 1'b0,1'b0,2'd0, 4'd8},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b1,2'd0,16'h0066, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b1,1'b0,2'd0, 4'd6},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b1,1'b0,2'd0, 4'd6},
        '{1'b1,5'd14,1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b1,1'b0,2'd0, 4'd2},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd1, 4'd6},
        '{1'b1,5'd15,1'b0,2'd0, 1'b1,2'd0,16'h0077, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd1, 4'd6},
        '{1'b1,5'd16,1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b1,2'd1, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd2, 4'd8},
        '{1'b1,5'd17,1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b1,5'd14,16'h0077, 1'b0,1'b0,2'd1, 4'd8},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b1,2'd1, 1'b0,5'd0, 16'h0000, 1'b0,1'b0,2'd2, 4'd8},
        '{1'b0,5'd0, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 1'b0,2'd0, 1'b0,5'd0, 16'h0000, 1'b1,1'b0,2'd1, 4'd8}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [REG_W-1:0]  iss_dest = '0;
    logic              iss_ready;
    logic [IDX_W-1:0]  iss_tag;
    logic              disp_valid = 1'b0;
    logic [IDX_W-1:0]  disp_tag = '0;
    logic              cmpl_valid = 1'b0;
    logic [IDX_W-1:0]  cmpl_tag = '0;
    logic [DATA_W-1:0] cmpl_data = '0;
    logic              flush_valid = 1'b0;
    logic [IDX_W-1:0]  flush_tag = '0;
    logic              ret_we;
    logic [REG_W-1:0]  ret_dest;
    logic [DATA_W-1:0] ret_data;
    logic              full;
    logic              empty;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    reorder_buf #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_reorder_buf (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dest(iss_dest), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .disp_valid(disp_valid), .disp_tag(disp_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_data(cmpl_data),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .ret_we(ret_we), .ret_dest(ret_dest), .ret_data(ret_data),
        .full(full), .empty(empty)
    );

    function automatic string rname(logic [3:0] n);
        case (n)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        iss_valid = 1'b0; disp_valid = 1'b0; cmpl_valid = 1'b0; flush_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failure.
    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Main sequence: reset, table walk, directed reset checks.
    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R1: state while held in reset after the first edges
        chk("R1", "empty", 32'(empty), 32'd1);
        chk("R1", "full", 32'(full), 32'd0);
        chk("R1", "iss_ready", 32'(iss_ready), 32'd1);
        chk("R1", "ret_we", 32'(ret_we), 32'd0);
        chk("R1", "iss_tag", 32'(iss_tag), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            iss_valid   = VEC[k].iv;   iss_dest  = VEC[k].idst;
            disp_valid  = VEC[k].dv;   disp_tag  = VEC[k].dt;
            cmpl_valid  = VEC[k].cv;   cmpl_tag  = VEC[k].ct;  cmpl_data = VEC[k].cd;
            flush_valid = VEC[k].fv;   flush_tag = VEC[k].ft;
            #5;
            chk(rname(VEC[k].req), "ret_we", 32'(ret_we), 32'(VEC[k].ewe));
            if (VEC[k].ewe) begin
                chk(rname(VEC[k].req), "ret_dest", 32'(ret_dest), 32'(VEC[k].edst));
                chk(rname(VEC[k].req), "ret_data", 32'(ret_data), 32'(VEC[k].edat));
            end
            chk(rname(VEC[k].req), "empty", 32'(empty), 32'(VEC[k].emp));
            chk(rname(VEC[k].req), "full", 32'(full), 32'(VEC[k].ful));
            chk(rname(VEC[k].req), "iss_ready", 32'(iss_ready), 32'(!VEC[k].ful));
            chk(rname(VEC[k].req), "iss_tag", 32'(iss_tag), 32'(VEC[k].etag));
            // R9: full and empty never together
            chk("R9", "full&empty", 32'(full && empty), 32'd0);
            @(negedge clk);
        end

        // Directed: fill two entries, then reset mid-run (R1).
        idle_inputs();
        iss_valid = 1'b1; iss_dest = 5'd20;
        @(negedge clk);
        iss_dest = 5'd21;
        @(negedge clk);
        idle_inputs();
        #5;
        chk("R2", "iss_tag before reset", 32'(iss_tag), 32'd3);
        chk("R9", "empty with live entries", 32'(empty), 32'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #5;
        chk("R1", "empty after reset", 32'(empty), 32'd1);
        chk("R1", "iss_tag after reset", 32'(iss_tag), 32'd0);
        chk("R1", "full after reset", 32'(full), 32'd0);
        chk("R1", "ret_we after reset", 32'(ret_we), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule